// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the bus-side engine for reading and writing registers in an Ethernet PHY over the two-wire management bus. The bus has a clock (MDC) and one shared data line (MDIO). MDIO is presented as three signals: a value to drive, an output enable, and the level seen on the pin. A host places a PHY address, a register address, a direction and, for writes, a 16-bit word on the inputs, then pulses `start`. The block produces the whole serial frame. It returns a one-cycle `done` pulse together with the read word and an error flag.

MDC is produced from the system clock. Each half period lasts `half_div` system clocks, and MDC rests high between transactions. On a read the master lets go of the line for the turnaround. The PHY must then pull the second turnaround bit low. When no PHY answers, the line stays high. The master then clocks the bus through a recovery run and reports all-ones with the error flag set. The master adds a few released clocks after every transaction.

Top module: `mdio_master`

## Requirements
- R1: Each MDC low phase and each high phase lasts `half_div` system clocks, and a value of 0 counts as 1. After reset and between transactions MDC is 1.
- R2: Every frame opens with 32 bit times in which the master drives MDIO to 1. The start pattern 0, 1 follows.
- R3: After the start pattern the master sends the opcode. A read is 1, 0 and a write is 0, 1. Next come the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R4: A bit time is one MDC low phase followed by one high phase. The master changes its driven MDIO value only in the system clock where MDC falls, and never while MDC is high.
- R5: On a read the master drives 46 bits and then releases MDIO (output enable 0) for both turnaround bit times. It samples the second turnaround bit.
- R6: If the sampled second turnaround bit is 1, the master gives 32 more bit times with MDIO released. It then ends with `rd_data` = 16'hFFFF and `error` = 1, for 80 MDC cycles in all.
- R7: If the second turnaround bit is 0, the master captures 16 data bits most significant bit first. Each bit is taken in the last system clock of its MDC high phase, through a two-flop synchronizer, so the PHY must hold each bit for at least 2 clocks before that point. Two released MDC cycles follow, for 66 in all. Then `rd_data` holds the word and `error` = 0.
- R8: On a write the master drives turnaround 1, 0 and then the 16 data bits most significant bit first. It then releases MDIO for one more MDC cycle, for 65 MDC cycles in all.
- R9: `done` is high for exactly one system clock. In that clock MDC is 1 and MDIO is released. `rd_data` and `error` change only in that clock. A write clears `error` and leaves `rd_data` unchanged.
- R10: A `start` pulse during a transaction is ignored. The current frame is unchanged and no extra `done` follows.
- R11: After reset MDC = 1, the output enable = 0, `done` = 0, `rd_data` = 0 and `error` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | MDC half period in system clocks (0 treated as 1) |
| start | input | 1 | Begin a transaction (one-cycle pulse) |
| is_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word read (16'hFFFF on error) |
| error | output | 1 | Set when no PHY answered the turnaround |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Level observed on MDIO |

## Verification
The bench models a PHY that changes its output on MDC falling edges. It records every bit on MDC rising edges and compares each driven bit against the frame. A master with the opcodes swapped, or with the addresses sent least significant bit first, fails the header comparison. A master that keeps driving through the turnaround shows an enabled bit where a released one is expected. The absent-PHY read counts the recovery cycles and checks the all-ones error result, so a missing or short recovery run changes the MDC count. A mid-frame `start` with different arguments, and a half period of 0, catch a master that restarts its frame or stalls the divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS     = 32;
  localparam int FRAME_W      = 64;
  localparam int RD_DRIVEN    = 46;
  localparam int WR_DRIVEN    = 64;
  localparam int TA_BITS      = 2;
  localparam int DATA_BITS    = 16;
  localparam int RECOVER_BITS = 32;
  localparam int RD_TAIL      = 2;
  localparam int WR_TAIL      = 1;
  localparam int CNT_W        = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_TURN, S_RDATA, S_RECOVER, S_TAIL
  } seq_state_t;

  // Left-aligned serial image of everything the master drives.
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic        rd,
    input logic [4:0]  pa,
    input logic [4:0]  ra,
    input logic [15:0] wd
  );
    logic [17:0] trail;
    trail = rd ? 18'h0 : {2'b10, wd};
    return {{PRE_BITS{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, trail};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick = run && (cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        tick,
  input  logic        line_in,
  output logic        run,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        error
);
  seq_state_t         state;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               half_hi;
  logic               rd_q;
  logic [15:0]        cap;
  logic [FRAME_W-1:0] frame;

  assign frame = build_frame(is_read, phy_addr, reg_addr, wr_data);
  assign run   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      shreg   <= '0;
      left    <= '0;
      half_hi <= 1'b0;
      rd_q    <= 1'b0;
      cap     <= '0;
      mdc     <= 1'b1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          rd_q    <= is_read;
          mdio_o  <= frame[FRAME_W-1];
          shreg   <= frame << 1;
          mdio_oe <= 1'b1;
          mdc     <= 1'b0;
          half_hi <= 1'b0;
          left    <= is_read ? CNT_W'(RD_DRIVEN - 1) : CNT_W'(WR_DRIVEN - 1);
          state   <= S_SHIFT;
        end
      end else if (tick) begin
        if (!half_hi) begin
          mdc     <= 1'b1;
          half_hi <= 1'b1;
        end else begin
          // end of a bit time: open the next low phase unless finishing
          half_hi <= 1'b0;
          mdc     <= 1'b0;
          if (state == S_RDATA) cap <= {cap[14:0], line_in};
          if (left != '0) begin
            left <= left - CNT_W'(1);
            if (state == S_SHIFT) begin
              mdio_o <= shreg[FRAME_W-1];
              shreg  <= shreg << 1;
            end
          end else begin
            case (state)
              S_SHIFT: begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b1;
                if (rd_q) begin
                  state <= S_TURN;
                  left  <= CNT_W'(TA_BITS - 1);
                end else begin
                  state <= S_TAIL;
                  left  <= CNT_W'(WR_TAIL - 1);
                end
              end
              S_TURN: begin
                if (line_in == 1'b0) begin
                  state <= S_RDATA;
                  left  <= CNT_W'(DATA_BITS - 1);
                end else begin
                  state <= S_RECOVER;
                  left  <= CNT_W'(RECOVER_BITS - 1);
                end
              end
              S_RDATA: begin
                state <= S_TAIL;
                left  <= CNT_W'(RD_TAIL - 1);
              end
              S_RECOVER: begin
                state   <= S_IDLE;
                mdc     <= 1'b1;
                done    <= 1'b1;
                rd_data <= 16'hFFFF;
                error   <= 1'b1;
              end
              S_TAIL: begin
                state <= S_IDLE;
                mdc   <= 1'b1;
                done  <= 1'b1;
                error <= 1'b0;
                if (rd_q) rd_data <= cap;
              end
              default: begin
                state <= S_IDLE;
                mdc   <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div,
  input  logic             start,
  input  logic             is_read,
  input  logic [4:0]       phy_addr,
  input  logic [4:0]       reg_addr,
  input  logic [15:0]      wr_data,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             error,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic run;
  logic tick;
  logic line_sync;

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .half_div(half_div), .tick(tick)
  );

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(mdio_i), .dout(line_sync)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .is_read(is_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .tick(tick), .line_in(line_sync), .run(run),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rd_data(rd_data), .error(error)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        error,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_DRIVE_CHANGE_LOW: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (mdc && !mdio_oe)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rd_data) || !$stable(error)) |-> done); // R9
  AST_ERROR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    error |-> (rd_data == 16'hFFFF)); // R6
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .rd_data(rd_data), .error(error),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int DIV_W = 8;
  localparam int TCLK  = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] half_div = 8'd2;
  logic             start = 1'b0;
  logic             is_read = 1'b0;
  logic [4:0]       phy_addr = '0;
  logic [4:0]       reg_addr = '0;
  logic [15:0]      wr_data = '0;
  logic             done;
  logic [15:0]      rd_data;
  logic             error;
  logic             mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_oe = 1'b0;
  logic        phy_o  = 1'b1;
  logic        phy_present = 1'b0;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_word = '0;

  int n_chk = 0;
  int n_bad = 0;

  logic cap_o  [0:127];
  logic cap_oe [0:127];
  int   fall_cnt = 0, rise_cnt = 0, done_cnt = 0, r4_viol = 0;
  logic rec = 1'b0;
  time  t_fall0, t_fall1, t_rise0;
  logic prev_mdc = 1'b1, prev_o = 1'b1, prev_oe = 1'b0;

  always #(TCLK/2) clk = ~clk;

  assign mdio_i = phy_oe ? phy_o : (mdio_oe ? mdio_o : 1'b1);

  mdio_master #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .half_div(half_div), .start(start), .is_read(is_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .done(done), .rd_data(rd_data), .error(error),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: updates its output just after each MDC falling edge
  always @(negedge mdc) begin
    if (rec) begin
      automatic int k = fall_cnt;
      fall_cnt = fall_cnt + 1;
      if (k == 0) t_fall0 = $time;
      if (k == 1) t_fall1 = $time;
      #1;
      if (phy_rd && phy_present && k == 47) begin
        phy_oe = 1'b1; phy_o = 1'b0;
      end else if (phy_rd && phy_present && k >= 48 && k < 64) begin
        phy_oe = 1'b1; phy_o = phy_word[15-(k-48)];
      end else begin
        phy_oe = 1'b0; phy_o = 1'b1;
      end
    end
  end

  always @(posedge mdc) begin
    if (rec) begin
      if (rise_cnt == 0) t_rise0 = $time;
      if (rise_cnt < 128) begin
        cap_o[rise_cnt]  = mdio_o;
        cap_oe[rise_cnt] = mdio_oe;
      end
      rise_cnt = rise_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt = done_cnt + 1;
      if (mdc && mdio_oe && prev_oe && (mdio_o != prev_o)) r4_viol = r4_viol + 1;
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int frame_errs(input logic [63:0] exp, input int lo, input int hi);
    int e = 0;
    for (int i = lo; i <= hi; i++)
      if (cap_oe[i] !== 1'b1 || cap_o[i] !== exp[63-i]) e++;
    return e;
  endfunction

  function automatic int released_errs(input int lo, input int hi);
    int e = 0;
    for (int i = lo; i <= hi; i++)
      if (cap_oe[i] !== 1'b0) e++;
    return e;
  endfunction

  // Runs one transaction; optionally pulses start again mid-frame.
  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [7:0] hd,
                         input logic present, input logic [15:0] word, input logic poke);
    int waited = 0;
    @(negedge clk);
    fall_cnt = 0; rise_cnt = 0; done_cnt = 0; r4_viol = 0;
    phy_rd = rd; phy_present = present; phy_word = word;
    half_div = hd; is_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    rec = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      is_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 done seen", {63'd0, done}, 64'd1);
    chk("R9 bus idle at done", {62'd0, mdc, mdio_oe}, {62'd0, 1'b1, 1'b0});
    @(negedge clk);
    chk("R9 done one cycle", {63'd0, done}, 64'd0);
    rec = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset outputs", {46'd0, mdc, mdio_oe, done, error, rd_data[13:0]},
        {46'd0, 1'b1, 1'b0, 1'b0, 1'b0, 14'd0});
    chk("R11 reset rd_data", {48'd0, rd_data}, 64'd0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [7:0] hd, input logic poke);
    logic [63:0] exp;
    int eff;
    eff = (hd == 0) ? 1 : hd;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
    run_txn(1'b0, pa, ra, wd, hd, 1'b0, 16'h0, poke);
    chk("R8 write MDC count", 64'(fall_cnt), 64'd65);
    chk("R2 preamble and start", 64'(frame_errs(exp, 0, 33)), 64'd0);
    chk("R3 write opcode and addresses", 64'(frame_errs(exp, 34, 45)), 64'd0);
    chk("R8 turnaround and data", 64'(frame_errs(exp, 46, 63)), 64'd0);
    chk("R8 released last cycle", 64'(released_errs(64, 64)), 64'd0);
    chk("R1 low phase length", 64'(t_rise0 - t_fall0), 64'(eff * TCLK));
    chk("R4 bit time length", 64'(t_fall1 - t_fall0), 64'(2 * eff * TCLK));
    chk("R4 no change while MDC high", 64'(r4_viol), 64'd0);
    chk("R9 write clears error", {63'd0, error}, 64'd0);
    if (poke) begin
      repeat (300) @(negedge clk);
      chk("R10 single done", 64'(done_cnt), 64'd1);
      chk("R10 bus stays idle", {62'd0, mdc, mdio_oe}, {62'd0, 1'b1, 1'b0});
    end
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [7:0] hd,
                        input logic present, input logic [15:0] word);
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 18'h0};
    run_txn(1'b1, pa, ra, 16'h0, hd, present, word, 1'b0);
    chk("R2 preamble and start", 64'(frame_errs(exp, 0, 33)), 64'd0);
    chk("R3 read opcode and addresses", 64'(frame_errs(exp, 34, 45)), 64'd0);
    chk("R5 turnaround released", 64'(released_errs(46, 47)), 64'd0);
    chk("R4 no change while MDC high", 64'(r4_viol), 64'd0);
    if (present) begin
      chk("R7 read MDC count", 64'(fall_cnt), 64'd66);
      chk("R7 read data", {48'd0, rd_data}, {48'd0, word});
      chk("R7 error clear", {63'd0, error}, 64'd0);
      chk("R7 released data and tail", 64'(released_errs(48, 65)), 64'd0);
    end else begin
      chk("R6 absent MDC count", 64'(fall_cnt), 64'd80);
      chk("R6 all ones", {48'd0, rd_data}, 64'hFFFF);
      chk("R6 error set", {63'd0, error}, 64'd1);
      chk("R6 recovery released", 64'(released_errs(48, 79)), 64'd0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(5'h1A, 5'h03, 16'hA5C3, 8'd2, 1'b0);
    t_read(5'h01, 5'h1F, 8'd3, 1'b1, 16'h8001);
    t_read(5'h12, 5'h05, 8'd2, 1'b0, 16'h0);
    t_write(5'h0F, 5'h10, 16'h0001, 8'd0, 1'b0);
    chk("R9 write keeps rd_data", {48'd0, rd_data}, 64'hFFFF);
    t_read(5'h15, 5'h0A, 8'd2, 1'b1, 16'h7E5A);
    t_write(5'h07, 5'h19, 16'h3C96, 8'd1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule